// File: doc/BRIEF.md
# Tile Shape Configuration Unit

This unit holds the shape of a small bank of two-dimensional matrix tile registers. Software or a sequencer fills a 64-byte staging record one word at a time, then issues a load command. The unit checks the staged record in one cycle. It then does one of three things: it commits the record, it forces the initial (unconfigured) state, or it reports a fault and keeps the active shape unchanged.

Downstream load, store and compute logic reads each tile's row count and bytes-per-row directly from flat output buses. The tile storage receives a one-cycle clear request whenever the unit returns to the initial state, either through a zero palette or through the release command. The active record can be read back one word at a time. While the unit is unconfigured, read-back returns only zeros.

Record layout, with bytes numbered from 0:
- Byte 0 holds the palette number.
- Bytes 48 to 48+TILES-1 hold one 8-bit row count per tile.
- Bytes 16 to 16+2*TILES-1 hold one 16-bit little-endian bytes-per-row value per tile.
- Every other byte is reserved.

Top module: `tcfg_unit`

## Requirements
- R1: After synchronous active-low reset, configured_o, fault_o and clear_o are 0, every tile row count and bytes-per-row output is 0, and read-back of any word returns 0.
- R2: A write stores wr_data_i into staging word wr_addr_i, which covers record bytes wr_addr_i*WORD_BYTES upward, with the lowest byte of the word in the lowest record byte. Staging writes do not change any output until a load is issued.
- R3: A load of a record whose palette is 1, with every field in range and every reserved byte zero, takes effect on the next clock edge. At that edge configured_o goes to 1, tile t's row count on tile_rows_o[8t+:8] equals record byte 48+t, and tile t's bytes-per-row on tile_bpr_o[16t+:16] equals {byte 17+2t, byte 16+2t}.
- R4: A load of a record whose palette is 0 enters the initial state on the next edge, whatever the other bytes hold. In that state configured_o is 0, all tile outputs are 0, and clear_o is high for exactly that one cycle, with fault_o low.
- R5: A load of a record whose palette is neither 0 nor 1 raises fault_o for one cycle on the next edge. The active state and all outputs other than fault_o stay unchanged.
- R6: Under palette 1, a row count above 16 or a bytes-per-row value above 64 on any tile causes a fault as in R5. The values 16 and 64 themselves are accepted.
- R7: Under palette 1, a nonzero reserved byte (any byte other than 0, the bytes-per-row bytes and the row-count bytes) causes a fault as in R5.
- R8: A release command enters the initial state on the next edge, with a one-cycle clear_o. When release and load are asserted in the same cycle, release wins: no fault and no commit occur.
- R9: rd_data_o presents active-record word rd_addr_i one cycle after it is addressed. The active record is palette byte 1 plus the committed fields, with zero in every reserved byte. While the unit is unconfigured, every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Staging word write strobe |
| wr_addr_i | input | AW | Staging word index |
| wr_data_i | input | 8*WORD_BYTES | Staging word data, little-endian bytes |
| load_i | input | 1 | Check and apply the staged record |
| release_i | input | 1 | Return to the initial state |
| rd_addr_i | input | AW | Read-back word index |
| rd_data_o | output | 8*WORD_BYTES | Read-back word, registered |
| configured_o | output | 1 | High while a valid palette-1 record is active |
| fault_o | output | 1 | One-cycle pulse on a rejected record |
| clear_o | output | 1 | One-cycle clear request to the tile storage |
| tile_rows_o | output | 8*TILES | Row count per tile |
| tile_bpr_o | output | 16*TILES | Bytes-per-row per tile |

## Verification
Every result of a load or release appears exactly one edge after the command is sampled: the commit or init, the fault pulse and the clear pulse. Read-back data appears one edge after its address. The bench therefore drives each command at a falling edge and samples one nanosecond after the following rising edge. That sampling point is the only instant at which fault_o and clear_o are observed high. A staged but unloaded record is checked at the outputs and through read-back before any load follows, and a second sample one cycle later confirms that the clear pulse lasts a single cycle.

// File: rtl/tcfg_pkg.sv
// Shared constants, the check decision type and the record-layout helper
// for the tile shape configuration unit. Assumes a 64-byte record.
package tcfg_pkg;

    localparam int REC_BYTES = 64;
    localparam int PAL_OFS   = 0;    // palette number byte
    localparam int BPR_OFS   = 16;   // first bytes-per-row byte (16-bit per tile)
    localparam int ROW_OFS   = 48;   // first row-count byte (8-bit per tile)
    localparam int MAX_TILES = 8;    // the layout has room for eight tiles

    // Outcome of checking a staged record
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_COMMIT = 2'd1,
        ACT_INIT   = 2'd2,
        ACT_FAULT  = 2'd3
    } act_e;

    // True when record byte b belongs to a defined field for the given tile count
    function automatic bit is_field(int b, int tiles);
        return (b == PAL_OFS) ||
               (b >= BPR_OFS && b < BPR_OFS + 2 * tiles) ||
               (b >= ROW_OFS && b < ROW_OFS + tiles);
    endfunction

endpackage

// File: rtl/tcfg_stage.sv
// Staging buffer: collects the 64-byte record one word at a time.
// Assumes WORD_BYTES divides the record size; bytes are little-endian in a word.
module tcfg_stage #(
    parameter int WORD_BYTES = 4,
    localparam int WORDS = tcfg_pkg::REC_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = 8 * WORD_BYTES
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [AW-1:0]                    wr_addr_i,
    input  logic [DW-1:0]                    wr_data_i,
    output logic [8*tcfg_pkg::REC_BYTES-1:0] rec_o
);

    // Store one staged word per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_o <= '0;
        end else if (wr_en_i) begin
            rec_o[wr_addr_i*DW +: DW] <= wr_data_i;
        end
    end

endmodule

// File: rtl/tcfg_check.sv
// Record checker: splits the staged record into per-tile fields and decides
// whether a load commits, forces init or faults. Purely combinational.
module tcfg_check #(
    parameter int TILES    = 8,
    parameter int MAX_ROWS = 16,
    parameter int MAX_BPR  = 64
) (
    input  logic [8*tcfg_pkg::REC_BYTES-1:0] rec_i,
    output logic [8*TILES-1:0]               rows_o,
    output logic [16*TILES-1:0]              bpr_o,
    output tcfg_pkg::act_e                   act_o
);
    import tcfg_pkg::*;

    logic [TILES-1:0]     over;
    logic [REC_BYTES-1:0] resv_nz;
    logic [7:0]           pal;

    assign pal = rec_i[PAL_OFS*8 +: 8];

    // Per-tile field extraction and range check
    for (genvar t = 0; t < TILES; t++) begin : g_tile
        assign rows_o[t*8 +: 8]   = rec_i[(ROW_OFS + t)*8 +: 8];
        assign bpr_o[t*16 +: 16]  = rec_i[(BPR_OFS + 2*t)*8 +: 16];
        assign over[t] = (rows_o[t*8 +: 8] > 8'(MAX_ROWS)) ||
                         (bpr_o[t*16 +: 16] > 16'(MAX_BPR));
    end

    // Reserved-byte scan: flags a nonzero byte outside every defined field
    for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
        if (is_field(b, TILES)) begin : g_fld
            assign resv_nz[b] = 1'b0;
        end else begin : g_res
            assign resv_nz[b] = |rec_i[b*8 +: 8];
        end
    end

    // Decision: a zero palette forces init before any other check
    always_comb begin
        if (pal == 8'd0)
            act_o = ACT_INIT;
        else if (pal != 8'd1 || |over || |resv_nz)
            act_o = ACT_FAULT;
        else
            act_o = ACT_COMMIT;
    end

endmodule

// File: rtl/tcfg_active.sv
// Active shape state: applies load and release commands, raises the fault and
// clear pulses, and serves registered read-back of the active record.
// Assumes release has priority over load; read-back rebuilds reserved bytes as zero.
module tcfg_active #(
    parameter int TILES      = 8,
    parameter int MAX_ROWS   = 16,
    parameter int MAX_BPR    = 64,
    parameter int WORD_BYTES = 4,
    localparam int WORDS = tcfg_pkg::REC_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = 8 * WORD_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                release_i,
    input  tcfg_pkg::act_e      act_i,
    input  logic [8*TILES-1:0]  rows_i,
    input  logic [16*TILES-1:0] bpr_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [DW-1:0]       rd_data_o,
    output logic                conf_o,
    output logic                fault_o,
    output logic                clear_o,
    output logic [8*TILES-1:0]  rows_o,
    output logic [16*TILES-1:0] bpr_o
);
    import tcfg_pkg::*;

    logic [8*REC_BYTES-1:0] img;

    // Command handling: release first, then the checked load outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_o  <= 1'b0;
            fault_o <= 1'b0;
            clear_o <= 1'b0;
            rows_o  <= '0;
            bpr_o   <= '0;
        end else begin
            fault_o <= 1'b0;
            clear_o <= 1'b0;
            if (release_i) begin
                conf_o  <= 1'b0;
                clear_o <= 1'b1;
                rows_o  <= '0;
                bpr_o   <= '0;
            end else if (load_i) begin
                unique case (act_i)
                    ACT_INIT: begin
                        conf_o  <= 1'b0;
                        clear_o <= 1'b1;
                        rows_o  <= '0;
                        bpr_o   <= '0;
                    end
                    ACT_COMMIT: begin
                        conf_o <= 1'b1;
                        rows_o <= rows_i;
                        bpr_o  <= bpr_i;
                    end
                    ACT_FAULT: fault_o <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Rebuild the active record image from the held fields
    always_comb begin
        img = '0;
        img[PAL_OFS*8 +: 8] = {7'd0, conf_o};
        for (int t = 0; t < TILES; t++) begin
            img[(BPR_OFS + 2*t)*8 +: 16] = bpr_o[t*16 +: 16];
            img[(ROW_OFS + t)*8 +: 8]    = rows_o[t*8 +: 8];
        end
    end

    // Registered read-back of one record word
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else
            rd_data_o <= img[rd_addr_i*DW +: DW];
    end

    // A fault leaves the active shape untouched (R5)
    p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (conf_o == $past(conf_o)) && (rows_o == $past(rows_o)) &&
                    (bpr_o == $past(bpr_o)));

    // A clear request always coincides with the empty initial state (R4)
    p_clear_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> !conf_o && rows_o == '0 && bpr_o == '0 && !fault_o);

    // Release wins over everything and clears on the next edge (R8)
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> clear_o && !conf_o && !fault_o);

    // Unconfigured means every tile shape reads zero (R9)
    p_unconf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !conf_o |-> rows_o == '0 && bpr_o == '0);

    // Active shapes never exceed the tile limits (R6)
    for (genvar t = 0; t < TILES; t++) begin : g_bound
        p_shape_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rows_o[t*8 +: 8] <= 8'(MAX_ROWS) && bpr_o[t*16 +: 16] <= 16'(MAX_BPR));
    end

endmodule

// File: rtl/tcfg_unit.sv
// Top of the tile shape configuration unit: staging buffer, record checker
// and active state. Assumes TILES <= 8 and WORD_BYTES dividing 64.
module tcfg_unit #(
    parameter int TILES      = 8,
    parameter int MAX_ROWS   = 16,
    parameter int MAX_BPR    = 64,
    parameter int WORD_BYTES = 4,
    localparam int WORDS = tcfg_pkg::REC_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(WORDS),
    localparam int DW    = 8 * WORD_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [DW-1:0]       wr_data_i,
    input  logic                load_i,
    input  logic                release_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [DW-1:0]       rd_data_o,
    output logic                configured_o,
    output logic                fault_o,
    output logic                clear_o,
    output logic [8*TILES-1:0]  tile_rows_o,
    output logic [16*TILES-1:0] tile_bpr_o
);
    import tcfg_pkg::*;

    logic [8*REC_BYTES-1:0] staged;
    logic [8*TILES-1:0]     chk_rows;
    logic [16*TILES-1:0]    chk_bpr;
    act_e                   chk_act;

    initial begin
        p_tile_count_fits: assert (TILES >= 1 && TILES <= MAX_TILES);
        p_word_divides: assert (REC_BYTES % WORD_BYTES == 0);
    end

    tcfg_stage #(.WORD_BYTES(WORD_BYTES)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rec_o     (staged)
    );

    tcfg_check #(.TILES(TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) u_check (
        .rec_i  (staged),
        .rows_o (chk_rows),
        .bpr_o  (chk_bpr),
        .act_o  (chk_act)
    );

    tcfg_active #(
        .TILES(TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR), .WORD_BYTES(WORD_BYTES)
    ) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .release_i (release_i),
        .act_i     (chk_act),
        .rows_i    (chk_rows),
        .bpr_i     (chk_bpr),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .conf_o    (configured_o),
        .fault_o   (fault_o),
        .clear_o   (clear_o),
        .rows_o    (tile_rows_o),
        .bpr_o     (tile_bpr_o)
    );

    // Read-back of an unconfigured unit is all zeros one cycle later (R9)
    p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !configured_o |=> rd_data_o == '0);

    // Staging writes alone never change the active shape (R2)
    p_stage_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !release_i |=> $stable(configured_o) && $stable(tile_rows_o) &&
                                  $stable(tile_bpr_o));

endmodule

// File: tb/sim_tcfg_unit.sv
// Self-checking bench for tcfg_unit: a vector table of records walked by one
// loop, followed by directed reset, staging, release and priority tests.
module sim_tcfg_unit;

    localparam int TILES = 8;
    localparam int WB    = 4;
    localparam int WORDS = 64 / WB;
    localparam int AW    = $clog2(WORDS);
    localparam int DW    = 8 * WB;

    typedef struct packed {
        logic [7:0]  pal;
        logic [2:0]  tsel;
        logic [7:0]  rows;
        logic [15:0] bpr;
        logic [5:0]  rbyte;
        logic [7:0]  rval;
        logic        bad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 3'd0, 8'd16, 16'd64,  6'd0,  8'h00, 1'b0},  // R6 limits accepted
        '{8'h01, 3'd3, 8'd17, 16'd8,   6'd0,  8'h00, 1'b1},  // R6 rows over
        '{8'h01, 3'd7, 8'd2,  16'd65,  6'd0,  8'h00, 1'b1},  // R6 bpr over
        '{8'h02, 3'd1, 8'd4,  16'd4,   6'd0,  8'h00, 1'b1},  // R5 palette 2
        '{8'h01, 3'd5, 8'd0,  16'd0,   6'd0,  8'h00, 1'b0},  // R3 empty tile
        '{8'h01, 3'd1, 8'd4,  16'd16,  6'd40, 8'h01, 1'b1},  // R7 reserved byte 40
        '{8'h01, 3'd2, 8'd8,  16'd256, 6'd0,  8'h00, 1'b1},  // R6 bpr high byte
        '{8'h00, 3'd2, 8'd8,  16'd32,  6'd2,  8'h05, 1'b0},  // R4 palette 0
        '{8'h01, 3'd6, 8'd1,  16'd1,   6'd0,  8'h00, 1'b0},  // R3 commit
        '{8'h01, 3'd2, 8'd8,  16'd32,  6'd1,  8'h80, 1'b1},  // R7 reserved byte 1
        '{8'hFF, 3'd0, 8'd1,  16'd1,   6'd0,  8'h00, 1'b1}   // R5 palette FF
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          load_i = 1'b0;
    logic          release_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          configured_o, fault_o, clear_o;
    logic [8*TILES-1:0]  tile_rows_o;
    logic [16*TILES-1:0] tile_bpr_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] recb [64];
    logic [7:0] exp_act [64];
    logic       exp_conf;

    always #2 clk = ~clk;

    tcfg_unit #(.TILES(TILES), .WORD_BYTES(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .load_i(load_i), .release_i(release_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .configured_o(configured_o),
        .fault_o(fault_o), .clear_o(clear_o), .tile_rows_o(tile_rows_o),
        .tile_bpr_o(tile_bpr_o)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Build a record from a table entry into recb
    task automatic build(input vec_t v);
        for (int b = 0; b < 64; b++) recb[b] = 8'h00;
        recb[0] = v.pal;
        for (int t = 0; t < TILES; t++) begin
            recb[48 + t]  = 8'(t + 1);
            recb[16 + 2*t] = 8'(4 * (t + 1));
        end
        recb[48 + v.tsel]     = v.rows;
        recb[16 + 2*v.tsel]   = v.bpr[7:0];
        recb[17 + 2*v.tsel]   = v.bpr[15:8];
        if (v.rval != 8'h00) recb[v.rbyte] = v.rval;
    endtask

    task automatic write_rec();
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            wr_en_i   = 1'b1;
            wr_addr_i = AW'(w);
            wr_data_i = {recb[w*WB+3], recb[w*WB+2], recb[w*WB+1], recb[w*WB]};
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic ld, input logic rl);
        @(negedge clk);
        load_i = ld;
        release_i = rl;
        @(posedge clk);
        #1;
        load_i = 1'b0;
        release_i = 1'b0;
    endtask

    task automatic read_word(input int w, output logic [DW-1:0] d);
        @(negedge clk);
        rd_addr_i = AW'(w);
        @(posedge clk);
        #1;
        d = rd_data_o;
    endtask

    function automatic logic [127:0] exp_rows();
        logic [127:0] r = '0;
        for (int t = 0; t < TILES; t++) r[t*8 +: 8] = exp_act[48 + t];
        return r;
    endfunction

    function automatic logic [127:0] exp_bpr();
        logic [127:0] r = '0;
        for (int t = 0; t < TILES; t++) r[t*16 +: 16] = {exp_act[17 + 2*t], exp_act[16 + 2*t]};
        return r;
    endfunction

    task automatic check_ports(input string tag);
        chk({tag, " configured"}, 128'(configured_o), 128'(exp_conf));
        chk({tag, " rows"}, 128'(tile_rows_o), exp_rows());
        chk({tag, " bpr"}, 128'(tile_bpr_o), exp_bpr());
    endtask

    task automatic check_readback(input string tag);
        logic [DW-1:0] d;
        for (int w = 0; w < WORDS; w++) begin
            read_word(w, d);
            chk($sformatf("%s R9 word %0d", tag, w), 128'(d),
                128'({exp_act[w*WB+3], exp_act[w*WB+2], exp_act[w*WB+1], exp_act[w*WB]}));
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < 64; b++) exp_act[b] = 8'h00;
        exp_conf = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 fault", 128'(fault_o), 128'(0));
        chk("R1 clear", 128'(clear_o), 128'(0));
        check_ports("R1");
        read_word(0, d);
        chk("R1 readback word 0", 128'(d), 128'(0));

        // Table walk: R3..R7
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vec%0d", i);
            build(VECS[i]);
            write_rec();
            pulse(1'b1, 1'b0);
            if (VECS[i].pal == 8'h00) begin
                clear_model();
            end else if (!VECS[i].bad) begin
                for (int b = 0; b < 64; b++) exp_act[b] = recb[b];
                exp_conf = 1'b1;
            end
            chk({tag, " R5 fault"}, 128'(fault_o), 128'(VECS[i].bad));
            chk({tag, " R4 clear"}, 128'(clear_o), 128'(VECS[i].pal == 8'h00));
            check_ports({tag, " R3"});
            check_readback(tag);
            chk({tag, " R5 fault one cycle"}, 128'(fault_o), 128'(0));
        end

        // R2: staging without load changes nothing; word byte order checked after load
        for (int b = 0; b < 64; b++) recb[b] = 8'h00;
        recb[0] = 8'h01;
        recb[48] = 8'd3; recb[51] = 8'd9;
        recb[16] = 8'd12; recb[17] = 8'd0; recb[22] = 8'd40;
        write_rec();
        repeat (2) @(posedge clk);
        #1;
        check_ports("R2 staged only");
        check_readback("R2 staged only");
        pulse(1'b1, 1'b0);
        for (int b = 0; b < 64; b++) exp_act[b] = recb[b];
        exp_conf = 1'b1;
        check_ports("R2 after load");

        // R8 release
        pulse(1'b0, 1'b1);
        clear_model();
        chk("R8 clear", 128'(clear_o), 128'(1));
        check_ports("R8 release");
        @(posedge clk);
        #1;
        chk("R8 clear one cycle", 128'(clear_o), 128'(0));
        check_readback("R8 unconfigured");

        // R8 priority: valid staged record loaded together with release
        pulse(1'b1, 1'b0);
        for (int b = 0; b < 64; b++) exp_act[b] = recb[b];
        exp_conf = 1'b1;
        check_ports("R8 reconfigure");
        pulse(1'b1, 1'b1);
        clear_model();
        chk("R8 priority clear", 128'(clear_o), 128'(1));
        chk("R8 priority fault", 128'(fault_o), 128'(0));
        check_ports("R8 priority");

        // R5 fault keeps an active configuration intact
        pulse(1'b1, 1'b0);
        for (int b = 0; b < 64; b++) exp_act[b] = recb[b];
        exp_conf = 1'b1;
        recb[0] = 8'h03;
        write_rec();
        pulse(1'b1, 1'b0);
        chk("R5 fault over active", 128'(fault_o), 128'(1));
        check_ports("R5 held");
        check_readback("R5 held");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule